// File: doc/BRIEF.md
# Write-Update Snooping Coherence Controller

This block holds the coherence state of a small, directly indexed array of cache lines for one processor's cache. The coherence scheme is a four-state write-update scheme. Writes to a line that other caches also hold send the new data to those caches instead of invalidating their copies. The states are exclusive-clean, shared-clean, shared-owned-dirty and modified. A wired shared signal on the bus decides where each miss lands and whether a write to a shared line must broadcast.

Requests from the processor side arrive as an operation code and a line index:
- read hit
- write hit
- read miss
- write miss
- eviction

The controller registers the resulting bus command and the new line state on the next clock edge.

On the snoop side it watches commands issued by other caches. It answers combinationally on its shared output. One cycle later it flags a flush it must supply or an update it must absorb. A combinational query port reports the presence and state of any line. Tag matching, data storage, memory and bus arbitration belong to the surrounding cache.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After a synchronous reset every line reads as not present on the query port, and `bus_cmd_out`, `snp_flush` and `snp_take_upd` are 0.
- R2: A read miss (`cpu_op` 3) puts bus read (`bus_cmd_out` 1) out in the next cycle. The line becomes present in shared-clean (state 1) if `bus_shared_in` was high in the request cycle, else exclusive-clean (state 0).
- R3: A write miss (`cpu_op` 4) puts bus read (1) out in the next cycle. The line becomes present in shared-owned (state 2) if `bus_shared_in` was high, else modified (state 3).
- R4: A read hit (`cpu_op` 1) in any state, and a write hit (`cpu_op` 2) in modified, leave the state unchanged and give `bus_cmd_out` 0 in the next cycle.
- R5: A write hit in exclusive-clean moves the line to modified with no bus command.
- R6: A write hit in shared-clean or shared-owned with `bus_shared_in` high gives bus update (`bus_cmd_out` 2) in the next cycle and leaves the line in shared-owned.
- R7: A write hit in shared-clean or shared-owned with `bus_shared_in` low moves the line to modified with no bus command.
- R8: A snooped bus read (`snp_cmd` 1) has these effects:
  - A modified line raises `snp_flush` in the next cycle and drops to shared-clean.
  - A shared-owned line raises `snp_flush` and stays shared-owned.
  - An exclusive-clean line goes to shared-clean without a flush.
  - A shared-clean line is unchanged.
- R9: A snooped bus update (`snp_cmd` 2) on a shared-owned line moves it to shared-clean. On a shared-clean line it leaves the line shared-clean. In both cases `snp_take_upd` rises in the next cycle.
- R10: `snp_shared_out` is high in the same cycle exactly when a snooped bus read or bus update addresses a present line. A snoop to a line that is not present changes nothing and raises no flag.
- R11: An eviction (`cpu_op` 5) of a shared-owned or modified line gives flush (`bus_cmd_out` 3) in the next cycle. An eviction of an exclusive-clean or shared-clean line gives no command. In both cases the line reads as not present afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_op | input | 3 | Processor operation: 0 idle, 1 read hit, 2 write hit, 3 read miss, 4 write miss, 5 evict |
| cpu_idx | input | IDXW | Line addressed by the processor operation |
| bus_shared_in | input | 1 | Wired shared signal, sampled with the processor operation |
| bus_cmd_out | output | 2 | Registered bus command: 0 none, 1 read, 2 update, 3 flush |
| snp_cmd | input | 2 | Snooped command from another cache, same encoding |
| snp_idx | input | IDXW | Line addressed by the snooped command |
| snp_shared_out | output | 1 | Combinational shared answer to the snooped command |
| snp_flush | output | 1 | Registered: this cache must supply the line |
| snp_take_upd | output | 1 | Registered: this cache must absorb update data |
| qry_idx | input | IDXW | Line to inspect |
| qry_valid | output | 1 | Inspected line is present |
| qry_state | output | 2 | Inspected line state: 0 exclusive-clean, 1 shared-clean, 2 shared-owned, 3 modified |

## Verification
The assertions take for granted that the surrounding cache sends only legal requests. Hit codes come only for present lines, and miss codes only for absent ones. A processor request and a snooped command never name the same line in the same cycle. Snooped updates never address a line this cache holds exclusively. The stimulus tracks its own model of every line and issues each hit, miss or snoop only where that model allows it. Paired processor and snoop operations always target different lines.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_EXCL   = 2'd0,
        ST_SHCLN  = 2'd1,
        ST_SHOWN  = 2'd2,
        ST_MOD    = 2'd3
    } line_st_t;

    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_RDHIT  = 3'd1,
        OP_WRHIT  = 3'd2,
        OP_RDMISS = 3'd3,
        OP_WRMISS = 3'd4,
        OP_EVICT  = 3'd5
    } cpu_op_t;

    typedef enum logic [1:0] {
        BC_NONE   = 2'd0,
        BC_READ   = 2'd1,
        BC_UPDATE = 2'd2,
        BC_FLUSH  = 2'd3
    } bus_cmd_t;

    typedef struct packed {
        logic     vld;
        line_st_t st;
    } line_t;

    typedef struct packed {
        logic     we;
        line_t    nxt;
        bus_cmd_t cmd;
    } proc_res_t;

    typedef struct packed {
        logic  we;
        line_t nxt;
        logic  flush;
        logic  take;
    } snp_res_t;

    function automatic logic is_dirty(line_st_t s);
        return (s == ST_SHOWN) || (s == ST_MOD);
    endfunction

endpackage

// File: rtl/coh_proc_fsm.sv
module coh_proc_fsm
    import coh_pkg::*;
(
    input  cpu_op_t   op,
    input  line_t     cur,
    input  logic      shared,
    output proc_res_t res
);
    always_comb begin
        res = '{we: 1'b0, nxt: cur, cmd: BC_NONE};
        unique case (op)
            OP_RDMISS: begin
                res.we  = 1'b1;
                res.cmd = BC_READ;
                res.nxt = '{vld: 1'b1, st: shared ? ST_SHCLN : ST_EXCL};
            end
            OP_WRMISS: begin
                res.we  = 1'b1;
                res.cmd = BC_READ;
                res.nxt = '{vld: 1'b1, st: shared ? ST_SHOWN : ST_MOD};
            end
            OP_WRHIT: begin
                if (cur.vld) begin
                    unique case (cur.st)
                        ST_EXCL: begin
                            res.we     = 1'b1;
                            res.nxt.st = ST_MOD;
                        end
                        ST_SHCLN, ST_SHOWN: begin
                            res.we = 1'b1;
                            if (shared) begin
                                res.cmd    = BC_UPDATE;
                                res.nxt.st = ST_SHOWN;
                            end else begin
                                res.nxt.st = ST_MOD;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            OP_EVICT: begin
                if (cur.vld) begin
                    res.we  = 1'b1;
                    res.nxt = '{vld: 1'b0, st: ST_EXCL};
                    res.cmd = is_dirty(cur.st) ? BC_FLUSH : BC_NONE;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/coh_snoop_fsm.sv
module coh_snoop_fsm
    import coh_pkg::*;
(
    input  bus_cmd_t cmd,
    input  line_t    cur,
    output snp_res_t res,
    output logic     hit_shared
);
    always_comb begin
        res        = '{we: 1'b0, nxt: cur, flush: 1'b0, take: 1'b0};
        hit_shared = cur.vld && (cmd == BC_READ || cmd == BC_UPDATE);
        if (cur.vld) begin
            unique case (cmd)
                BC_READ: begin
                    unique case (cur.st)
                        ST_MOD: begin
                            res.we     = 1'b1;
                            res.flush  = 1'b1;
                            res.nxt.st = ST_SHCLN;
                        end
                        ST_SHOWN: res.flush = 1'b1;
                        ST_EXCL: begin
                            res.we     = 1'b1;
                            res.nxt.st = ST_SHCLN;
                        end
                        default: ;
                    endcase
                end
                BC_UPDATE: begin
                    if (cur.st == ST_SHOWN || cur.st == ST_SHCLN) begin
                        res.we     = 1'b1;
                        res.take   = 1'b1;
                        res.nxt.st = ST_SHCLN;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/coh_line_store.sv
module coh_line_store
    import coh_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDXW = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            p_we,
    input  logic [IDXW-1:0] p_idx,
    input  line_t           p_line,
    input  logic            s_we,
    input  logic [IDXW-1:0] s_idx,
    input  line_t           s_line,
    input  logic [IDXW-1:0] q_idx,
    output line_t           p_cur,
    output line_t           s_cur,
    output line_t           q_cur
);
    line_t lines [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        line_t line_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                line_q <= '{vld: 1'b0, st: ST_EXCL};
            end else if (p_we && p_idx == IDXW'(i)) begin
                line_q <= p_line;
            end else if (s_we && s_idx == IDXW'(i)) begin
                line_q <= s_line;
            end
        end
        assign lines[i] = line_q;
    end

    assign p_cur = lines[p_idx];
    assign s_cur = lines[s_idx];
    assign q_cur = lines[q_idx];

    p_evict_gone_r11: assert property (@(posedge clk) disable iff (rst)
        (p_we && !p_line.vld) |=> !lines[$past(p_idx)].vld);
endmodule

// File: rtl/upd_coh_ctrl.sv
module upd_coh_ctrl
    import coh_pkg::*;
#(
    parameter int LINES = 16,
    localparam int IDXW = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      cpu_op,
    input  logic [IDXW-1:0] cpu_idx,
    input  logic            bus_shared_in,
    output logic [1:0]      bus_cmd_out,
    input  logic [1:0]      snp_cmd,
    input  logic [IDXW-1:0] snp_idx,
    output logic            snp_shared_out,
    output logic            snp_flush,
    output logic            snp_take_upd,
    input  logic [IDXW-1:0] qry_idx,
    output logic            qry_valid,
    output logic [1:0]      qry_state
);
    cpu_op_t   op_c;
    bus_cmd_t  snp_c;
    line_t     p_cur, s_cur, q_cur;
    proc_res_t p_res;
    snp_res_t  s_res;
    bus_cmd_t  cmd_q;
    logic      flush_q, take_q;

    assign op_c  = cpu_op_t'(cpu_op);
    assign snp_c = bus_cmd_t'(snp_cmd);

    coh_line_store #(.LINES(LINES)) store_i (
        .clk    (clk),
        .rst    (rst),
        .p_we   (p_res.we),
        .p_idx  (cpu_idx),
        .p_line (p_res.nxt),
        .s_we   (s_res.we),
        .s_idx  (snp_idx),
        .s_line (s_res.nxt),
        .q_idx  (qry_idx),
        .p_cur  (p_cur),
        .s_cur  (s_cur),
        .q_cur  (q_cur)
    );

    coh_proc_fsm proc_i (
        .op     (op_c),
        .cur    (p_cur),
        .shared (bus_shared_in),
        .res    (p_res)
    );

    coh_snoop_fsm snoop_i (
        .cmd        (snp_c),
        .cur        (s_cur),
        .res        (s_res),
        .hit_shared (snp_shared_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= BC_NONE;
            flush_q <= 1'b0;
            take_q  <= 1'b0;
        end else begin
            cmd_q   <= p_res.cmd;
            flush_q <= s_res.flush;
            take_q  <= s_res.take;
        end
    end

    assign bus_cmd_out  = cmd_q;
    assign snp_flush    = flush_q;
    assign snp_take_upd = take_q;
    assign qry_valid    = q_cur.vld;
    assign qry_state    = q_cur.st;

    // Input contract: processor and snoop never address the same line together (R10)
    p_no_line_clash_r10: assert property (@(posedge clk) disable iff (rst)
        (op_c != OP_IDLE && snp_c != BC_NONE) |-> (cpu_idx != snp_idx));

    p_rdhit_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (op_c == OP_RDHIT) |=> (bus_cmd_out == BC_NONE));

    p_update_needs_shared_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_cmd_out == BC_UPDATE) |-> ($past(bus_shared_in) && $past(op_c) == OP_WRHIT));

    p_flush_after_read_r8: assert property (@(posedge clk) disable iff (rst)
        snp_flush |-> ($past(snp_c) == BC_READ));

    p_take_after_update_r9: assert property (@(posedge clk) disable iff (rst)
        snp_take_upd |-> ($past(snp_c) == BC_UPDATE));

    p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({snp_flush, snp_take_upd}));

    p_miss_reads_bus_r2: assert property (@(posedge clk) disable iff (rst)
        (op_c == OP_RDMISS || op_c == OP_WRMISS) |=> (bus_cmd_out == BC_READ));
endmodule

// File: tb/upd_coh_ctrl_tb_top.sv
`timescale 1ns/1ps
module upd_coh_ctrl_tb_top;
    localparam int LINES = 16;
    localparam int IDXW  = $clog2(LINES);
    localparam realtime CLK_HALF = 2.0;

    logic            clk = 1'b0;
    logic            rst;
    logic [2:0]      cpu_op;
    logic [IDXW-1:0] cpu_idx;
    logic            bus_shared_in;
    logic [1:0]      bus_cmd_out;
    logic [1:0]      snp_cmd;
    logic [IDXW-1:0] snp_idx;
    logic            snp_shared_out, snp_flush, snp_take_upd;
    logic [IDXW-1:0] qry_idx;
    logic            qry_valid;
    logic [1:0]      qry_state;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [1:0] cmd;
        logic       fl;
        logic       tk;
        string      tag;
    } exp_t;
    exp_t pend[$];

    logic       m_v [LINES];
    logic [1:0] m_s [LINES];

    always #(CLK_HALF) clk = ~clk;

    upd_coh_ctrl #(.LINES(LINES)) dut_i (
        .clk(clk), .rst(rst), .cpu_op(cpu_op), .cpu_idx(cpu_idx),
        .bus_shared_in(bus_shared_in), .bus_cmd_out(bus_cmd_out),
        .snp_cmd(snp_cmd), .snp_idx(snp_idx), .snp_shared_out(snp_shared_out),
        .snp_flush(snp_flush), .snp_take_upd(snp_take_upd),
        .qry_idx(qry_idx), .qry_valid(qry_valid), .qry_state(qry_state)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // monitor: scoreboard pops one expected item per driven operation
    always @(posedge clk) begin
        #1;
        if (pend.size() > 0) begin
            exp_t e;
            e = pend.pop_front();
            check({e.tag, " bus_cmd"}, {6'd0, bus_cmd_out}, {6'd0, e.cmd});
            check({e.tag, " flush"}, {7'd0, snp_flush}, {7'd0, e.fl});
            check({e.tag, " take_upd"}, {7'd0, snp_take_upd}, {7'd0, e.tk});
        end
    end

    // one cycle: processor op and/or snoop; expected values from the requirement table
    task automatic step(input logic [2:0] op, input int pi, input logic sh,
                        input logic [1:0] sc, input int si, input string tag);
        exp_t e;
        logic exp_sh;
        e.cmd = 2'd0; e.fl = 1'b0; e.tk = 1'b0; e.tag = tag;
        @(negedge clk);
        cpu_op = op; cpu_idx = IDXW'(pi); bus_shared_in = sh;
        snp_cmd = sc; snp_idx = IDXW'(si);
        exp_sh = m_v[si] && (sc == 2'd1 || sc == 2'd2);
        #1;
        if (sc != 2'd0) check({tag, " shared_out R10"}, {7'd0, snp_shared_out}, {7'd0, exp_sh});
        case (op)
            3'd2: if (m_s[pi] == 2'd0) m_s[pi] = 2'd3;
                  else if (m_s[pi] == 2'd1 || m_s[pi] == 2'd2) begin
                      if (sh) begin e.cmd = 2'd2; m_s[pi] = 2'd2; end
                      else m_s[pi] = 2'd3;
                  end
            3'd3: begin e.cmd = 2'd1; m_v[pi] = 1'b1; m_s[pi] = sh ? 2'd1 : 2'd0; end
            3'd4: begin e.cmd = 2'd1; m_v[pi] = 1'b1; m_s[pi] = sh ? 2'd2 : 2'd3; end
            3'd5: begin
                if (m_s[pi] >= 2'd2) e.cmd = 2'd3;
                m_v[pi] = 1'b0; m_s[pi] = 2'd0;
            end
            default: ;
        endcase
        if (m_v[si]) begin
            if (sc == 2'd1) begin
                if (m_s[si] == 2'd3) begin e.fl = 1'b1; m_s[si] = 2'd1; end
                else if (m_s[si] == 2'd2) e.fl = 1'b1;
                else if (m_s[si] == 2'd0) m_s[si] = 2'd1;
            end else if (sc == 2'd2 && (m_s[si] == 2'd1 || m_s[si] == 2'd2)) begin
                e.tk = 1'b1; m_s[si] = 2'd1;
            end
        end
        pend.push_back(e);
        @(negedge clk);
        cpu_op = 3'd0; snp_cmd = 2'd0;
    endtask

    task automatic chk_line(input int i, input string tag);
        @(negedge clk);
        qry_idx = IDXW'(i);
        #1;
        check({tag, " valid"}, {7'd0, qry_valid}, {7'd0, m_v[i]});
        if (m_v[i]) check({tag, " state"}, {6'd0, qry_state}, {6'd0, m_s[i]});
    endtask

    initial begin
        #(CLK_HALF * 2 * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin m_v[i] = 1'b0; m_s[i] = 2'd0; end
        rst = 1'b1; cpu_op = 3'd0; cpu_idx = '0; bus_shared_in = 1'b0;
        snp_cmd = 2'd0; snp_idx = '0; qry_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        check("R1 bus_cmd", {6'd0, bus_cmd_out}, 8'd0);
        check("R1 flush", {7'd0, snp_flush}, 8'd0);
        check("R1 take", {7'd0, snp_take_upd}, 8'd0);
        for (int i = 0; i < LINES; i++) chk_line(i, "R1 reset line");

        // misses
        step(3'd3, 0, 1'b0, 2'd0, 0, "R2 rdmiss unshared");  chk_line(0, "R2");
        step(3'd3, 1, 1'b1, 2'd0, 0, "R2 rdmiss shared");    chk_line(1, "R2");
        step(3'd4, 2, 1'b0, 2'd0, 0, "R3 wrmiss unshared");  chk_line(2, "R3");
        step(3'd4, 3, 1'b1, 2'd0, 0, "R3 wrmiss shared");    chk_line(3, "R3");
        // read hits in each state, write hit in M
        for (int i = 0; i < 4; i++) begin
            step(3'd1, i, 1'b1, 2'd0, 0, "R4 read hit");
            chk_line(i, "R4");
        end
        step(3'd2, 2, 1'b1, 2'd0, 0, "R4 write hit M");     chk_line(2, "R4");
        // write hits
        step(3'd2, 0, 1'b1, 2'd0, 0, "R5 write hit E");     chk_line(0, "R5");
        step(3'd2, 1, 1'b1, 2'd0, 0, "R6 write Sc shared"); chk_line(1, "R6");
        step(3'd2, 3, 1'b1, 2'd0, 0, "R6 write Sm shared"); chk_line(3, "R6");
        step(3'd4, 4, 1'b1, 2'd0, 0, "R3 wrmiss 4");
        step(3'd2, 4, 1'b0, 2'd0, 0, "R7 write Sm alone");  chk_line(4, "R7");
        step(3'd3, 5, 1'b1, 2'd0, 0, "R2 rdmiss 5");
        step(3'd2, 5, 1'b0, 2'd0, 0, "R7 write Sc alone");  chk_line(5, "R7");
        // snooped reads, with a concurrent processor op on another line
        step(3'd3, 6, 1'b0, 2'd1, 2, "R8 snoop rd M");      chk_line(2, "R8");
        step(3'd0, 0, 1'b0, 2'd1, 3, "R8 snoop rd Sm");     chk_line(3, "R8");
        step(3'd0, 0, 1'b0, 2'd1, 6, "R8 snoop rd E");      chk_line(6, "R8");
        step(3'd1, 0, 1'b0, 2'd1, 6, "R8 snoop rd Sc");     chk_line(6, "R8");
        // snooped updates
        step(3'd0, 0, 1'b0, 2'd2, 3, "R9 snoop upd Sm");    chk_line(3, "R9");
        step(3'd0, 0, 1'b0, 2'd2, 6, "R9 snoop upd Sc");    chk_line(6, "R9");
        // snoop misses
        step(3'd0, 0, 1'b0, 2'd1, 9, "R10 snoop rd absent");  chk_line(9, "R10");
        step(3'd0, 0, 1'b0, 2'd2, 9, "R10 snoop upd absent"); chk_line(9, "R10");
        // evictions
        step(3'd5, 2, 1'b0, 2'd0, 0, "R11 evict Sc");       chk_line(2, "R11");
        step(3'd5, 0, 1'b0, 2'd0, 0, "R11 evict M");        chk_line(0, "R11");
        step(3'd4, 7, 1'b1, 2'd0, 0, "R3 wrmiss 7");
        step(3'd5, 7, 1'b0, 2'd0, 0, "R11 evict Sm");       chk_line(7, "R11");
        step(3'd3, 8, 1'b0, 2'd0, 0, "R2 rdmiss 8");
        step(3'd5, 8, 1'b0, 2'd0, 0, "R11 evict E");        chk_line(8, "R11");
        for (int i = 0; i < LINES; i++) chk_line(i, "R4 final sweep");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule